// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is the switch inside one tile of a two-dimensional mesh interconnect. It links the tile's resource block (the local port) to up to four neighbouring switches (north, south, east, west). Each port is a pair of one-way links, one inbound and one outbound, each with a valid/ready handshake. Packets cross the mesh as fixed-width flits. Only the first flit of a packet carries an address.

Each inbound link has a small flit FIFO. The head flit at the front of a FIFO is routed by dimension order: X first, then Y. The result is a request to one outbound port. Each outbound port has its own round-robin arbiter. Once a packet wins an outbound port, that port belongs to it until its tail flit has left. Later flits of the packet simply follow the head, so packets are never interleaved on a link.

The router's mesh position and the mesh size are parameters. A switch on the mesh boundary is built without the links that would face outside the mesh.

Top module: `mesh_flit_router`

## Requirements
- R1: A flit is `PAYLOAD_W+2` bits wide.
  - Its two top bits give its kind: 2'b01 opens a packet, 2'b00 is a middle flit, 2'b10 closes a packet, and 2'b11 is a packet of one flit.
  - In an opening or single flit, bits [COORD_W-1:0] hold the destination X and bits [2*COORD_W-1:COORD_W] hold the destination Y.
- R2: Port indices are 0 local, 1 north (towards larger Y), 2 east (towards larger X), 3 south and 4 west.
  - An addressed flit leaves east or west while its destination X differs from the router's X.
  - Otherwise it leaves north or south while its destination Y differs from the router's Y.
  - Otherwise it leaves on the local port.
- R3: A port facing outside the mesh is absent.
  - Its in_ready and out_valid are held at 0, and any flit offered on it is ignored.
  - If the next hop for a flit would be an absent port, the flit is delivered on the local port instead.
- R4: Middle and closing flits carry no address. They leave on the same port as the opening flit that came before them on the same input, whatever their low bits hold.
- R5: From the cycle an opening flit is accepted on an output until the cycle its closing flit is accepted, that output carries only flits from the same input.
- R6: Among inputs contending for a free output, the grant goes round-robin. The search starts at the input after the last one served, and input 0 is searched first after reset.
- R7: Each input buffers FIFO_DEPTH flits (default 4).
  - in_ready is 0 while that many flits are held.
  - No accepted flit is lost.
- R8: Flits leave unmodified and in their arrival order per input. Once out_valid is high, it and out_flit stay stable until out_ready is seen.
- R9: A flit accepted at a clock edge is offered on its free output during the following cycle.
- R10: During and just after reset, every out_valid is 0, and in_ready is 1 on every present port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per input port: a flit is offered |
| in_ready | output | 5 | Per input port: the FIFO has room |
| in_flit | input | 5*(PAYLOAD_W+2) | Inbound flits; port p occupies slice p |
| out_valid | output | 5 | Per output port: a flit is offered |
| out_ready | input | 5 | Per output port: the neighbour takes the flit |
| out_flit | output | 5*(PAYLOAD_W+2) | Outbound flits; port p occupies slice p |

## Verification
The checker confirms several properties on every cycle:
- absent ports stay silent, and no route ever points at one;
- each output grants at most one input;
- a stalled output keeps its flit stable;
- a closing flit releases the output, and a held output keeps its owner;
- each FIFO's occupancy changes exactly as the handshakes and pops dictate.

Other behaviours can be shown only by the bench's scenarios:
- the routing decision for every destination code from every input, on a centre router and a corner router;
- the absence of interleaving between two worms contending for one link;
- the round-robin order among four stalled senders;
- no loss when a FIFO fills;
- the one-cycle pass-through latency.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  localparam int NP = 5;
  localparam int PW = 3;
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_SOUTH = 3;
  localparam int P_WEST  = 4;

  typedef enum logic [1:0] {
    FK_MID    = 2'b00,
    FK_OPEN   = 2'b01,
    FK_CLOSE  = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  // flit carries a destination address
  function automatic logic is_addressed(input logic [1:0] kind);
    return (kind == FK_OPEN) || (kind == FK_SINGLE);
  endfunction

  // flit releases the output it holds
  function automatic logic is_last(input logic [1:0] kind);
    return (kind == FK_CLOSE) || (kind == FK_SINGLE);
  endfunction

  // which ports exist for a router at (x,y) in an mx by my mesh
  function automatic logic [NP-1:0] port_mask(input int x, input int y, input int mx, input int my);
    logic [NP-1:0] m;
    m          = '0;
    m[P_LOCAL] = 1'b1;
    m[P_NORTH] = (y < my - 1);
    m[P_EAST]  = (x < mx - 1);
    m[P_SOUTH] = (y > 0);
    m[P_WEST]  = (x > 0);
    return m;
  endfunction

  // dimension-order next hop, local when the wanted port is absent
  function automatic int unsigned dor_port(input int unsigned cx, input int unsigned cy,
                                           input int unsigned dx, input int unsigned dy,
                                           input logic [NP-1:0] pres);
    int unsigned r;
    if (dx > cx)      r = P_EAST;
    else if (dx < cx) r = P_WEST;
    else if (dy > cy) r = P_NORTH;
    else if (dy < cy) r = P_SOUTH;
    else              r = P_LOCAL;
    if (!pres[r]) r = P_LOCAL;
    return r;
  endfunction
endpackage

// File: rtl/mfr_fifo.sv
module mfr_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] v);
    return (v == AW'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/mfr_route.sv
module mfr_route import mfr_pkg::*; #(
  parameter int              COORD_W = 2,
  parameter int              X_POS   = 1,
  parameter int              Y_POS   = 1,
  parameter logic [NP-1:0]   PRESENT = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [1:0]         kind,
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  input  logic               pop,
  output logic [NP-1:0]      req
);
  logic [PW-1:0] held_port;
  logic [PW-1:0] cur_port;

  always_comb begin
    if (is_addressed(kind))
      cur_port = PW'(dor_port(32'(X_POS), 32'(Y_POS), 32'(dest_x), 32'(dest_y), PRESENT));
    else
      cur_port = held_port;
  end

  assign req = valid ? (NP'(1) << cur_port) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      held_port <= PW'(P_LOCAL);
    else if (pop && is_addressed(kind))
      held_port <= cur_port;
  end
endmodule

// File: rtl/mfr_out_arb.sv
module mfr_out_arb import mfr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic [NP-1:0] last,
  input  logic          ready,
  output logic [NP-1:0] grant,
  output logic [PW-1:0] gidx,
  output logic          gvalid,
  output logic          xfer,
  output logic          lock,
  output logic [PW-1:0] owner
);
  logic [PW-1:0] ptr;
  logic [PW-1:0] pick;
  logic          pick_ok;
  int unsigned   cand;

  always_comb begin
    pick    = ptr;
    pick_ok = 1'b0;
    cand    = 0;
    for (int k = 0; k < NP; k++) begin
      cand = (int'(ptr) + k) % NP;
      if (!pick_ok && req[cand]) begin
        pick_ok = 1'b1;
        pick    = PW'(cand);
      end
    end
  end

  always_comb begin
    if (lock) begin
      gidx   = owner;
      gvalid = req[owner];
    end else begin
      gidx   = pick;
      gvalid = pick_ok;
    end
  end

  assign grant = gvalid ? (NP'(1) << gidx) : '0;
  assign xfer  = gvalid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock  <= 1'b0;
      owner <= '0;
      ptr   <= '0;
    end else if (gvalid && !ready) begin
      lock  <= 1'b1;
      owner <= gidx;
    end else if (xfer) begin
      lock  <= !last[gidx];
      owner <= gidx;
      ptr   <= (gidx == PW'(NP - 1)) ? '0 : gidx + 1'b1;
    end
  end
endmodule

// File: rtl/mesh_flit_router.sv
module mesh_flit_router import mfr_pkg::*; #(
  parameter int COORD_W    = 2,
  parameter int PAYLOAD_W  = 8,
  parameter int MESH_X     = 3,
  parameter int MESH_Y     = 3,
  parameter int X_POS      = 1,
  parameter int Y_POS      = 1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NP-1:0]                 in_valid,
  output logic [NP-1:0]                 in_ready,
  input  logic [NP*(PAYLOAD_W+2)-1:0]   in_flit,
  output logic [NP-1:0]                 out_valid,
  input  logic [NP-1:0]                 out_ready,
  output logic [NP*(PAYLOAD_W+2)-1:0]   out_flit
);
  localparam int            FLIT_W  = PAYLOAD_W + 2;
  localparam int            CW      = $clog2(FIFO_DEPTH + 1);
  localparam logic [NP-1:0] PRESENT = port_mask(X_POS, Y_POS, MESH_X, MESH_Y);

  // named internal events, observed by the bound checker
  logic [NP*FLIT_W-1:0] front;
  logic [NP-1:0]        fifo_empty, fifo_full, fifo_pop, front_last;
  logic [NP*CW-1:0]     fifo_cnt;
  logic [NP*NP-1:0]     route_req;   // slice i: outputs wanted by input i
  logic [NP*NP-1:0]     col_req;     // slice o: inputs wanting output o
  logic [NP*NP-1:0]     grant_mat;   // slice o: input granted on output o
  logic [NP-1:0]        out_lock, out_xfer;
  logic [NP*PW-1:0]     out_owner, out_gidx;

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        col_req[o*NP+i] = route_req[i*NP+o];
  end

  always_comb begin
    fifo_pop = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        fifo_pop[i] = fifo_pop[i] | (out_xfer[o] & grant_mat[o*NP+i]);
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    if (PRESENT[p]) begin : g_on
      logic [1:0] kind;
      assign kind = front[p*FLIT_W+FLIT_W-2 +: 2];
      assign front_last[p] = is_last(kind);
      assign in_ready[p] = !fifo_full[p];

      mfr_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid[p]),
        .din   (in_flit[p*FLIT_W +: FLIT_W]),
        .pop   (fifo_pop[p]),
        .dout  (front[p*FLIT_W +: FLIT_W]),
        .empty (fifo_empty[p]),
        .full  (fifo_full[p]),
        .count (fifo_cnt[p*CW +: CW])
      );

      mfr_route #(.COORD_W(COORD_W), .X_POS(X_POS), .Y_POS(Y_POS), .PRESENT(PRESENT)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (!fifo_empty[p]),
        .kind   (kind),
        .dest_x (front[p*FLIT_W +: COORD_W]),
        .dest_y (front[p*FLIT_W+COORD_W +: COORD_W]),
        .pop    (fifo_pop[p]),
        .req    (route_req[p*NP +: NP])
      );

      mfr_out_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (col_req[p*NP +: NP]),
        .last   (front_last),
        .ready  (out_ready[p]),
        .grant  (grant_mat[p*NP +: NP]),
        .gidx   (out_gidx[p*PW +: PW]),
        .gvalid (out_valid[p]),
        .xfer   (out_xfer[p]),
        .lock   (out_lock[p]),
        .owner  (out_owner[p*PW +: PW])
      );

      // crossbar column for this output
      assign out_flit[p*FLIT_W +: FLIT_W] = front[32'(out_gidx[p*PW +: PW])*FLIT_W +: FLIT_W];
    end else begin : g_off
      logic unused_absent;
      assign unused_absent = ^{in_valid[p], out_ready[p], in_flit[p*FLIT_W +: FLIT_W]};
      assign in_ready[p]   = 1'b0;
      assign out_valid[p]  = 1'b0;
      assign out_flit[p*FLIT_W +: FLIT_W] = '0;
      assign front[p*FLIT_W +: FLIT_W]    = '0;
      assign fifo_empty[p] = 1'b1;
      assign fifo_full[p]  = 1'b0;
      assign front_last[p] = 1'b0;
      assign fifo_cnt[p*CW +: CW]   = '0;
      assign route_req[p*NP +: NP]  = '0;
      assign grant_mat[p*NP +: NP]  = '0;
      assign out_xfer[p]  = 1'b0;
      assign out_lock[p]  = 1'b0;
      assign out_owner[p*PW +: PW] = '0;
      assign out_gidx[p*PW +: PW]  = '0;
    end
  end
endmodule

// File: rtl/mfr_checker.sv
module mfr_checker import mfr_pkg::*; #(
  parameter int FLIT_W     = 10,
  parameter int CW         = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int MESH_X     = 3,
  parameter int MESH_Y     = 3,
  parameter int X_POS      = 1,
  parameter int Y_POS      = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NP-1:0]        in_valid,
  input logic [NP-1:0]        in_ready,
  input logic [NP-1:0]        out_valid,
  input logic [NP-1:0]        out_ready,
  input logic [NP*FLIT_W-1:0] out_flit,
  input logic [NP*CW-1:0]     fifo_cnt,
  input logic [NP-1:0]        fifo_pop,
  input logic [NP-1:0]        out_lock,
  input logic [NP-1:0]        out_xfer,
  input logic [NP*PW-1:0]     out_owner,
  input logic [NP*NP-1:0]     grant_mat,
  input logic [NP*NP-1:0]     route_req
);
  localparam logic [NP-1:0] PRES = port_mask(X_POS, Y_POS, MESH_X, MESH_Y);

  for (genvar p = 0; p < NP; p++) begin : g_chk
    if (!PRES[p]) begin : g_absent
      p_absent_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready[p] && !out_valid[p]);
    end

    p_route_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (route_req[p*NP +: NP] & ~PRES) == '0);

    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_mat[p*NP +: NP]));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_flit[p*FLIT_W +: FLIT_W])));

    p_last_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_xfer[p] && is_last(out_flit[p*FLIT_W+FLIT_W-2 +: 2])) |=> !out_lock[p]);

    p_owner_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_lock[p] |=> (!out_lock[p] || $stable(out_owner[p*PW +: PW])));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_cnt[p*CW +: CW]) <= FIFO_DEPTH);

    p_count_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (int'(fifo_cnt[p*CW +: CW]) == int'($past(fifo_cnt[p*CW +: CW]))
                        + ($past(in_valid[p] && in_ready[p]) ? 1 : 0)
                        - ($past(fifo_pop[p]) ? 1 : 0)));
  end
endmodule

bind mesh_flit_router mfr_checker #(
  .FLIT_W(FLIT_W), .CW(CW), .FIFO_DEPTH(FIFO_DEPTH),
  .MESH_X(MESH_X), .MESH_Y(MESH_Y), .X_POS(X_POS), .Y_POS(Y_POS)
) i_mfr_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
  .fifo_cnt(fifo_cnt), .fifo_pop(fifo_pop), .out_lock(out_lock),
  .out_xfer(out_xfer), .out_owner(out_owner), .grant_mat(grant_mat),
  .route_req(route_req)
);

// File: tb/test_mesh_flit_router.sv
module test_mesh_flit_router;
  localparam int NP = 5;
  localparam int FW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic [NP-1:0]    c_in_valid = '0, c_in_ready, c_out_valid, c_out_ready = '1;
  logic [NP*FW-1:0] c_in_flit = '0, c_out_flit;
  logic [NP-1:0]    e_in_valid = '0, e_in_ready, e_out_valid, e_out_ready = '1;
  logic [NP*FW-1:0] e_in_flit = '0, e_out_flit;

  mesh_flit_router #(.X_POS(1), .Y_POS(1)) i_mesh_flit_router (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready), .in_flit(c_in_flit),
    .out_valid(c_out_valid), .out_ready(c_out_ready), .out_flit(c_out_flit));

  mesh_flit_router #(.X_POS(2), .Y_POS(2)) i_mesh_flit_router_edge (
    .clk(clk), .rst_n(rst_n), .in_valid(e_in_valid), .in_ready(e_in_ready), .in_flit(e_in_flit),
    .out_valid(e_out_valid), .out_ready(e_out_ready), .out_flit(e_out_flit));

  int total = 0;
  int bad = 0;
  logic [FW-1:0] c_log [NP][64];
  logic [FW-1:0] e_log [NP][64];
  int c_cnt [NP];
  int e_cnt [NP];

  // transfers are recorded between edges; they complete at the next rising edge
  always @(negedge clk) begin
    #1ns;
    for (int p = 0; p < NP; p++) begin
      if (rst_n && c_out_valid[p] && c_out_ready[p] && c_cnt[p] < 64) begin
        c_log[p][c_cnt[p]] = c_out_flit[p*FW +: FW];
        c_cnt[p]++;
      end
      if (rst_n && e_out_valid[p] && e_out_ready[p] && e_cnt[p] < 64) begin
        e_log[p][e_cnt[p]] = e_out_flit[p*FW +: FW];
        e_cnt[p]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    for (int p = 0; p < NP; p++) begin
      c_cnt[p] = 0;
      e_cnt[p] = 0;
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] kind, input logic [3:0] tag,
                                       input int dx, input int dy);
    return {kind, tag, 2'(dy), 2'(dx)};
  endfunction

  // expected next hop, written from the requirement text
  function automatic int want_port(input int cx, input int cy, input int dx, input int dy,
                                   input logic [NP-1:0] pres);
    int r;
    int ddx = dx - cx;
    int ddy = dy - cy;
    if (ddx != 0)      r = (ddx > 0) ? 2 : 4;
    else if (ddy != 0) r = (ddy > 0) ? 1 : 3;
    else               r = 0;
    if (!pres[r]) r = 0;
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    c_in_valid = '0;
    e_in_valid = '0;
    c_out_ready = '1;
    e_out_ready = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_logs();
  endtask

  // called at a falling edge, returns at the falling edge after acceptance
  task automatic c_send(input int p, input logic [FW-1:0] f);
    bit ok;
    c_in_valid[p] = 1'b1;
    c_in_flit[p*FW +: FW] = f;
    do begin
      #1ns;
      ok = c_in_ready[p];
      @(negedge clk);
    end while (!ok);
    c_in_valid[p] = 1'b0;
  endtask

  task automatic e_send(input int p, input logic [FW-1:0] f);
    bit ok;
    e_in_valid[p] = 1'b1;
    e_in_flit[p*FW +: FW] = f;
    do begin
      #1ns;
      ok = e_in_ready[p];
      @(negedge clk);
    end while (!ok);
    e_in_valid[p] = 1'b0;
  endtask

  task automatic c_pkt(input int p, input logic [1:0] grp, input int dx, input int dy);
    for (int j = 0; j < 4; j++) begin
      logic [1:0] k;
      k = (j == 0) ? 2'b01 : ((j == 3) ? 2'b10 : 2'b00);
      if (j == 0) c_send(p, mk(k, {grp, 2'(j)}, dx, dy));
      else        c_send(p, mk(k, {grp, 2'(j)}, 0, 0));
    end
  endtask

  initial begin
    #800us;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_logs();
    @(negedge clk);
    #1ns;
    // R10 reset state
    chk(c_out_valid == '0 && e_out_valid == '0, "R10 out_valid in reset", int'(c_out_valid), 0);
    do_reset();
    #1ns;
    chk(c_in_ready == 5'b11111, "R10 centre in_ready after reset", int'(c_in_ready), 5'h1f);
    chk(e_in_ready == 5'b11001, "R10 R3 edge in_ready after reset", int'(e_in_ready), 5'h19);
    chk(c_out_valid == '0 && e_out_valid == '0, "R10 out_valid after reset", int'(c_out_valid | e_out_valid), 0);
    @(negedge clk);

    // R1 R2 R8: every input, every destination code, centre router (1,1)
    for (int p = 0; p < NP; p++)
      for (int dx = 0; dx < 4; dx++)
        for (int dy = 0; dy < 4; dy++) begin
          logic [FW-1:0] f;
          int w, tot;
          f = mk(2'b11, 4'(p * 3 + dx), dx, dy);
          clear_logs();
          c_send(p, f);
          repeat (3) @(negedge clk);
          w = want_port(1, 1, dx, dy, 5'b11111);
          tot = c_cnt[0] + c_cnt[1] + c_cnt[2] + c_cnt[3] + c_cnt[4];
          chk(tot == 1 && c_cnt[w] == 1 && c_log[w][0] == f, "R2 R1 R8 dimension-order route",
              (tot == 1 && c_cnt[w] == 1) ? int'(c_log[w][0]) : tot, int'(f));
        end

    // R3: corner router (2,2), present inputs only
    for (int pi = 0; pi < 3; pi++)
      for (int dx = 0; dx < 4; dx++)
        for (int dy = 0; dy < 4; dy++) begin
          logic [FW-1:0] f;
          int p, w, tot;
          p = (pi == 0) ? 0 : pi + 2;
          f = mk(2'b11, 4'(dx * 4 + dy), dx, dy);
          clear_logs();
          e_send(p, f);
          repeat (3) @(negedge clk);
          w = want_port(2, 2, dx, dy, 5'b11001);
          tot = e_cnt[0] + e_cnt[1] + e_cnt[2] + e_cnt[3] + e_cnt[4];
          chk(tot == 1 && e_cnt[w] == 1 && e_log[w][0] == f, "R3 edge route falls back to local",
              (tot == 1 && e_cnt[w] == 1) ? int'(e_log[w][0]) : tot, int'(f));
        end

    // R3: a flit offered on an absent port is ignored
    clear_logs();
    e_in_valid[1] = 1'b1;
    e_in_flit[1*FW +: FW] = mk(2'b11, 4'h5, 2, 2);
    repeat (5) @(negedge clk);
    #1ns;
    chk(e_in_ready[1] == 1'b0, "R3 absent port in_ready", int'(e_in_ready[1]), 0);
    chk(e_cnt[0] + e_cnt[1] + e_cnt[2] + e_cnt[3] + e_cnt[4] == 0, "R3 absent port input ignored",
        e_cnt[0] + e_cnt[3] + e_cnt[4], 0);
    chk(e_out_valid[1] == 1'b0 && e_out_valid[2] == 1'b0, "R3 absent port out_valid",
        int'(e_out_valid), 0);
    e_in_valid[1] = 1'b0;
    @(negedge clk);

    // R9: one-cycle pass-through
    do_reset();
    c_send(0, mk(2'b11, 4'h9, 2, 1));
    #1ns;
    chk(c_out_valid[2] == 1'b1 && c_out_flit[2*FW +: FW] == mk(2'b11, 4'h9, 2, 1),
        "R9 offered the cycle after acceptance", int'(c_out_valid[2]), 1);
    @(negedge clk);

    // R4 R5: two worms contend for east
    do_reset();
    fork
      c_pkt(4, 2'b10, 2, 1);
      c_pkt(3, 2'b11, 2, 0);
    join
    repeat (12) @(negedge clk);
    chk(c_cnt[2] == 8, "R5 both worms delivered east", c_cnt[2], 8);
    chk(c_cnt[0] + c_cnt[1] + c_cnt[3] + c_cnt[4] == 0, "R4 no flit follows its own low bits",
        c_cnt[0] + c_cnt[1] + c_cnt[3] + c_cnt[4], 0);
    if (c_cnt[2] == 8) begin
      for (int g = 0; g < 2; g++) begin
        bit same;
        same = 1'b1;
        for (int j = 0; j < 4; j++) begin
          logic [FW-1:0] f;
          logic [1:0] k;
          f = c_log[2][g*4+j];
          k = (j == 0) ? 2'b01 : ((j == 3) ? 2'b10 : 2'b00);
          if (f[7:6] != c_log[2][g*4][7:6] || f[5:4] != 2'(j) || f[9:8] != k) same = 1'b0;
        end
        chk(same, "R5 R4 worm not interleaved and in order", int'(c_log[2][g*4+1]), int'(g));
      end
    end

    // R6 R8: four stalled senders, round-robin release order from input 0
    do_reset();
    c_out_ready[2] = 1'b0;
    fork
      begin c_send(0, mk(2'b11, 4'b0000, 2, 1)); c_send(0, mk(2'b11, 4'b0001, 2, 1)); end
      begin c_send(1, mk(2'b11, 4'b0010, 2, 1)); c_send(1, mk(2'b11, 4'b0011, 2, 1)); end
      begin c_send(3, mk(2'b11, 4'b0110, 2, 1)); c_send(3, mk(2'b11, 4'b0111, 2, 1)); end
      begin c_send(4, mk(2'b11, 4'b1000, 2, 1)); c_send(4, mk(2'b11, 4'b1001, 2, 1)); end
    join
    repeat (3) @(negedge clk);
    chk(c_cnt[2] == 0, "R8 nothing leaves while out_ready is low", c_cnt[2], 0);
    c_out_ready[2] = 1'b1;
    repeat (12) @(negedge clk);
    chk(c_cnt[2] == 8, "R6 all contenders served", c_cnt[2], 8);
    for (int k = 0; k < 8; k++) begin
      int src;
      logic [3:0] exp_tag;
      src = (k % 4 == 0) ? 0 : ((k % 4 == 1) ? 1 : ((k % 4 == 2) ? 3 : 4));
      exp_tag = {3'(src), 1'(k / 4)};
      chk(c_cnt[2] > k && c_log[2][k][7:4] == exp_tag, "R6 round-robin order",
          int'(c_log[2][k][7:4]), int'(exp_tag));
    end

    // R7 R8: fill one FIFO, no loss
    do_reset();
    c_out_ready[2] = 1'b0;
    for (int j = 0; j < 4; j++) c_send(4, mk(2'b11, 4'(j), 2, 1));
    #1ns;
    chk(c_in_ready[4] == 1'b0, "R7 in_ready low when full", int'(c_in_ready[4]), 0);
    chk(c_in_ready[3] == 1'b1, "R7 other input unaffected", int'(c_in_ready[3]), 1);
    @(negedge clk);
    c_out_ready[2] = 1'b1;
    c_send(4, mk(2'b11, 4'd4, 2, 1));
    repeat (8) @(negedge clk);
    chk(c_cnt[2] == 5, "R7 no flit dropped", c_cnt[2], 5);
    for (int j = 0; j < 5; j++)
      chk(c_cnt[2] > j && c_log[2][j] == mk(2'b11, 4'(j), 2, 1), "R8 arrival order kept",
          int'(c_log[2][j]), int'(mk(2'b11, 4'(j), 2, 1)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule